// File: doc/BRIEF.md
# Four-Channel I/Q Serial Output Formatter

The formatter takes one synchronous set of complex samples from four receive channels (an I word and a Q word per channel) and sends the set out as a frame of eight words on four output pins. A programmable divider sets the bit rate from the core clock. The formatter offers three word-interleave patterns. It deals the ordered words over one, two or four serial streams, and routes each stream to any pin through a per-pin selector. A nibble option sends each word four bits at a time across all four pins instead.

A frame starts when the producer pulses `smp_valid` with a complete sample set and the formatter is idle. The samples, the channel enables and the configuration bytes are captured at that moment and stay fixed for the frame. The bit-rate field is the only setting that acts live. Channel A is always sent. Channels B to D can be switched off, and their slots then carry zero words, so the positions of the other words do not move. The serial clock is provided as a strobe (`sck_en`), one core-clock cycle wide, and the pins change only in strobe cycles.

Top module: `ser_out_fmt`

## Requirements
- R1: `sck_en` goes high once every `clk_cfg[3:0]`+1 core cycles, so it stays high in every cycle when the field is 0.
- R2: `clk_cfg[5:4]` gives 1 active stream (value 0), 2 streams (value 1) or 4 streams (values 2 and 3). A stream index at or above the active count drives data 0 and never a frame mark.
- R3: Order mode `clk_cfg[7:6]`=0 sends the slots as IA, QA, IB, QB, IC, QC, ID, QD.
- R4: Order mode 1 sends IA, IB, QA, QB, IC, ID, QC, QD.
- R5: Order modes 2 and 3 both send IA, IB, IC, ID, QA, QB, QC, QD.
- R6: Slot k of the ordered sequence goes to stream k mod N as that stream's word number k div N, where N is the active stream count. Each word is 16 bits, sent MSB first with one bit per strobe, and the stream's frame mark is high exactly on the strobe that carries the word's MSB.
- R7: When `ch_en[c]`=0 for c in 1..3, the I and Q slots of channel c carry 0x0000 in their usual positions. `ch_en[0]` has no effect.
- R8: Output pin k takes the stream selected by `mux_cfg[2k+1:2k]` (0=A, 1=B, 2=C, 3=D), for both data and frame mark. Several pins may select the same stream.
- R9: With `nibble_en`=1, the ordered slots are sent as a single sequence at 4 bits per strobe, most significant nibble first. Nibble bit j appears on pin j, or on pin 3-j when `mux_cfg[1:0]`=1. All four frame marks are high on the first nibble of each word, and `clk_cfg[5:4]` is ignored.
- R10: A frame starts only on `smp_valid` while idle. A `smp_valid` during a frame is ignored, and after the last bit the pins send 0 with no frame mark.
- R11: While `rst_n` is low, `pin_dat`, `pin_fs` and `sck_en` are 0, and no frame resumes after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_cfg | input | 8 | [3:0] bit-rate divisor, [5:4] stream count, [7:6] order mode |
| mux_cfg | input | 8 | Two-bit stream select per output pin |
| nibble_en | input | 1 | Send words as nibbles across all pins |
| ch_en | input | 4 | Channel enables, bit c for channel c (bit 0 ignored) |
| smp_valid | input | 1 | Pulse: a complete sample set is present |
| smp_i | input | 64 | I words, channel c at bits 16c+15:16c |
| smp_q | input | 64 | Q words, channel c at bits 16c+15:16c |
| sck_en | output | 1 | Serial clock strobe |
| pin_dat | output | 4 | Serial data pins |
| pin_fs | output | 4 | Per-pin frame mark (first bit of a word) |

## Verification
The assertions assume that the bit-rate field is steady whenever they compare it with strobe timing, and that the configuration, enable and sample inputs matter only in the cycle of an accepted `smp_valid`. The stimulus changes all configuration at a falling edge while the block is idle, just before it raises `smp_valid` for one cycle. In every frame it also raises `smp_valid` once more with inverted samples, to show that the captured set does not change. Reset is applied once at power-up and once in the middle of a frame.

// File: rtl/sof_pkg.sv
package sof_pkg;

   typedef enum logic [1:0] {
      ORD_PAIRS = 2'd0,
      ORD_CPLX  = 2'd1,
      ORD_GROUP = 2'd2,
      ORD_GRP2  = 2'd3
   } ord_e;

   // log2 of the active stream count for a stream-count field value
   function automatic logic [1:0] stream_shift(input logic [1:0] fld);
      case (fld)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/sof_clkdiv.sv
module sof_clkdiv #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   logic [RATE_W-1:0] cnt;

   assign tick = (cnt >= rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/sof_slot_map.sv
module sof_slot_map
   import sof_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int NUM_CH = 4,
   parameter int SLOT_W = 3
) (
   input  ord_e                     ord,
   input  logic [SLOT_W-1:0]        slot,
   input  logic [NUM_CH*WORD_W-1:0] smp_i,
   input  logic [NUM_CH*WORD_W-1:0] smp_q,
   input  logic [NUM_CH-1:0]        ch_on,
   output logic [WORD_W-1:0]        word
);

   localparam int CH_W = $clog2(NUM_CH);

   logic [CH_W-1:0] ch;
   logic            isq;

   always_comb begin
      case (ord)
         ORD_PAIRS: begin ch = slot[2:1];           isq = slot[0]; end
         ORD_CPLX:  begin ch = {slot[2], slot[0]}; isq = slot[1]; end
         default:   begin ch = slot[1:0];           isq = slot[2]; end
      endcase
      if (!ch_on[ch])  word = '0;
      else if (isq)    word = smp_q[ch*WORD_W +: WORD_W];
      else             word = smp_i[ch*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/sof_pin_mux.sv
module sof_pin_mux #(
   parameter int NUM_PINS = 4,
   parameter int NUM_STM  = 4
) (
   input  logic [NUM_STM-1:0]           stm_dat,
   input  logic [NUM_STM-1:0]           stm_fs,
   input  logic [NUM_PINS-1:0]          nib_dat,
   input  logic                         nib_fs,
   input  logic                         nib_mode,
   input  logic [NUM_PINS*$clog2(NUM_STM)-1:0] sel_cfg,
   output logic [NUM_PINS-1:0]          pin_dat,
   output logic [NUM_PINS-1:0]          pin_fs
);

   localparam int SEL_W = $clog2(NUM_STM);

   logic rev;
   assign rev = (sel_cfg[SEL_W-1:0] == SEL_W'(1));

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      logic [SEL_W-1:0] sel;
      assign sel = sel_cfg[k*SEL_W +: SEL_W];
      assign pin_dat[k] = nib_mode ? (rev ? nib_dat[NUM_PINS-1-k] : nib_dat[k])
                                   : stm_dat[sel];
      assign pin_fs[k]  = nib_mode ? nib_fs : stm_fs[sel];
   end

endmodule

// File: rtl/ser_out_fmt.sv
module ser_out_fmt
   import sof_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int NUM_CH = 4,
   parameter int RATE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               clk_cfg,
   input  logic [7:0]               mux_cfg,
   input  logic                     nibble_en,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic                     smp_valid,
   input  logic [NUM_CH*WORD_W-1:0] smp_i,
   input  logic [NUM_CH*WORD_W-1:0] smp_q,
   output logic                     sck_en,
   output logic [3:0]               pin_dat,
   output logic [3:0]               pin_fs
);

   localparam int NUM_STM  = 4;
   localparam int NUM_PINS = 4;
   localparam int SLOTS    = 2 * NUM_CH;
   localparam int SLOT_W   = $clog2(SLOTS);
   localparam int BIT_W    = $clog2(WORD_W);
   localparam int NIB_PER  = WORD_W / 4;
   localparam int NIB_W    = $clog2(NIB_PER);
   localparam logic [BIT_W-1:0]  BIT_TOP = BIT_W'(WORD_W - 1);
   localparam logic [BIT_W-1:0]  NIB_TOP = BIT_W'(NIB_PER - 1);
   localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(SLOTS - 1);

   if (NUM_CH != 4) begin : g_bad_ch
      $error("ser_out_fmt: order modes are defined for exactly four channels");
   end
   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_w
      $error("ser_out_fmt: WORD_W must be a power of two of at least 8");
   end
   if (RATE_W > 8) begin : g_bad_rate
      $error("ser_out_fmt: RATE_W exceeds the configuration byte");
   end

   logic                     tick;
   logic                     busy;
   logic [BIT_W-1:0]         bit_pos;
   logic [SLOT_W-1:0]        wrd_pos;
   logic [NUM_CH*WORD_W-1:0] i_q, q_q;
   logic [NUM_CH-1:0]        en_q;
   ord_e                     ord_q;
   logic [1:0]               scnt_q;
   logic                     nib_q;
   logic [7:0]               mux_q;

   logic [1:0]               sh;
   logic [BIT_W-1:0]         last_bit;
   logic [SLOT_W-1:0]        last_wrd;
   logic [NUM_STM-1:0]       stm_dat, stm_fs;
   logic [WORD_W-1:0]        word0;
   logic [WORD_W-1:0]        nib_sh;
   logic [3:0]               mux_dat, mux_fs;

   sof_clkdiv #(.RATE_W(RATE_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .rate (clk_cfg[RATE_W-1:0]),
      .tick (tick)
   );

   assign sh       = nib_q ? 2'd0 : stream_shift(scnt_q);
   assign last_bit = nib_q ? NIB_TOP : BIT_TOP;
   assign last_wrd = SLOT_TOP >> sh;

   for (genvar s = 0; s < NUM_STM; s++) begin : g_stm
      logic [SLOT_W-1:0] slot;
      logic [WORD_W-1:0] word;
      logic              act;
      assign slot = (wrd_pos << sh) | SLOT_W'(s);
      assign act  = (sh == 2'd2) ? 1'b1 : (sh == 2'd1) ? (s < 2) : (s == 0);
      sof_slot_map #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_map (
         .ord  (ord_q),
         .slot (slot),
         .smp_i(i_q),
         .smp_q(q_q),
         .ch_on(en_q),
         .word (word)
      );
      assign stm_dat[s] = act & word[BIT_TOP - bit_pos];
      assign stm_fs[s]  = act & (bit_pos == '0);
   end

   assign word0  = g_stm[0].word;
   assign nib_sh = word0 << {bit_pos[NIB_W-1:0], 2'b00};

   sof_pin_mux #(.NUM_PINS(NUM_PINS), .NUM_STM(NUM_STM)) u_mux (
      .stm_dat (stm_dat),
      .stm_fs  (stm_fs),
      .nib_dat (nib_sh[WORD_W-1 -: 4]),
      .nib_fs  (bit_pos == '0),
      .nib_mode(nib_q),
      .sel_cfg (mux_q),
      .pin_dat (mux_dat),
      .pin_fs  (mux_fs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_pos <= '0;
         wrd_pos <= '0;
         i_q     <= '0;
         q_q     <= '0;
         en_q    <= '0;
         ord_q   <= ORD_PAIRS;
         scnt_q  <= '0;
         nib_q   <= 1'b0;
         mux_q   <= '0;
         sck_en  <= 1'b0;
         pin_dat <= '0;
         pin_fs  <= '0;
      end else begin
         sck_en <= tick;
         if (!busy && smp_valid) begin
            busy    <= 1'b1;
            bit_pos <= '0;
            wrd_pos <= '0;
            i_q     <= smp_i;
            q_q     <= smp_q;
            en_q    <= ch_en | NUM_CH'(1);
            ord_q   <= ord_e'(clk_cfg[7:6]);
            scnt_q  <= clk_cfg[5:4];
            nib_q   <= nibble_en;
            mux_q   <= mux_cfg;
         end
         if (tick) begin
            if (busy) begin
               pin_dat <= mux_dat;
               pin_fs  <= mux_fs;
               if (bit_pos == last_bit) begin
                  bit_pos <= '0;
                  if (wrd_pos == last_wrd) begin
                     busy    <= 1'b0;
                     wrd_pos <= '0;
                  end else begin
                     wrd_pos <= wrd_pos + 1'b1;
                  end
               end else begin
                  bit_pos <= bit_pos + 1'b1;
               end
            end else begin
               pin_dat <= '0;
               pin_fs  <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/sof_fmt_chk.sv
module sof_fmt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] clk_cfg,
   input logic       smp_valid,
   input logic       sck_en,
   input logic [3:0] pin_dat,
   input logic [3:0] pin_fs,
   input logic       busy,
   input logic       nib_q
);

   AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      clk_cfg[3:0] == 4'd0 |=> sck_en);                                   // R1

   AST_MARK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_fs[0]) |-> sck_en);                                       // R6

   AST_NIB_MARK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      sck_en && $past(busy) && nib_q |-> (pin_fs == 4'h0 || pin_fs == 4'hF)); // R9

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sck_en && !$past(busy) |-> (pin_dat == 4'h0 && pin_fs == 4'h0));   // R10

   AST_START_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(smp_valid));                                 // R10

endmodule

bind ser_out_fmt sof_fmt_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_cfg  (clk_cfg),
   .smp_valid(smp_valid),
   .sck_en   (sck_en),
   .pin_dat  (pin_dat),
   .pin_fs   (pin_fs),
   .busy     (busy),
   .nib_q    (nib_q)
);

// File: tb/ser_out_fmt_tb_top.sv
module ser_out_fmt_tb_top;

   localparam int CLK_P = 10;
   localparam int NV    = 10;

   // {frame strobes[28:21], clk_cfg[20:13], mux_cfg[12:5], nibble[4], ch_en[3:0]}
   localparam logic [28:0] VEC [NV] = '{
      {8'd128, 8'h00, 8'hE4, 1'b0, 4'hF},
      {8'd64,  8'h52, 8'hE4, 1'b0, 4'hF},
      {8'd32,  8'hB1, 8'hE4, 1'b0, 4'hF},
      {8'd32,  8'hE0, 8'h1B, 1'b0, 4'hF},
      {8'd64,  8'h53, 8'h00, 1'b0, 4'hA},
      {8'd32,  8'hB0, 8'hE4, 1'b0, 4'h0},
      {8'd64,  8'h10, 8'h50, 1'b0, 4'h6},
      {8'd32,  8'h01, 8'hE4, 1'b1, 4'hF},
      {8'd32,  8'hB0, 8'hE5, 1'b1, 4'h5},
      {8'd128, 8'h0F, 8'hE4, 1'b0, 4'hF}
   };
   string VTAG [NV] = '{
      "R3 R2 R6", "R4 R6", "R5 R6", "R5 R2 R8", "R4 R7 R8",
      "R5 R7", "R3 R7 R8", "R9 R3", "R9 R5 R7", "R3 R1"
   };

   localparam logic [15:0] BI [4] = '{16'hA5C3, 16'h1E2D, 16'h7F01, 16'h0F96};
   localparam logic [15:0] BQ [4] = '{16'hC35A, 16'hB4E1, 16'h0280, 16'h6699};
   localparam int O0C [8] = '{0, 0, 1, 1, 2, 2, 3, 3};
   localparam int O0Q [8] = '{0, 1, 0, 1, 0, 1, 0, 1};
   localparam int O1C [8] = '{0, 1, 0, 1, 2, 3, 2, 3};
   localparam int O1Q [8] = '{0, 0, 1, 1, 0, 0, 1, 1};
   localparam int O2C [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
   localparam int O2Q [8] = '{0, 0, 0, 0, 1, 1, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  clk_cfg = 8'h00;
   logic [7:0]  mux_cfg = 8'hE4;
   logic        nibble_en = 1'b0;
   logic [3:0]  ch_en = 4'hF;
   logic        smp_valid = 1'b0;
   logic [63:0] smp_i, smp_q;
   logic        sck_en;
   logic [3:0]  pin_dat, pin_fs;
   logic [63:0] base_i, base_q;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   ser_out_fmt dut_i (
      .clk(clk), .rst_n(rst_n), .clk_cfg(clk_cfg), .mux_cfg(mux_cfg),
      .nibble_en(nibble_en), .ch_en(ch_en), .smp_valid(smp_valid),
      .smp_i(smp_i), .smp_q(smp_q), .sck_en(sck_en),
      .pin_dat(pin_dat), .pin_fs(pin_fs)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic [1:0] ord, input int slot,
                                            input logic [3:0] en);
      int ch, q;
      case (ord)
         2'd0:    begin ch = O0C[slot]; q = O0Q[slot]; end
         2'd1:    begin ch = O1C[slot]; q = O1Q[slot]; end
         default: begin ch = O2C[slot]; q = O2Q[slot]; end
      endcase
      if (ch != 0 && !en[ch]) return 16'h0000;
      return (q != 0) ? BQ[ch] : BI[ch];
   endfunction

   task automatic model(input logic [7:0] cc, input logic [7:0] mc, input logic nb,
                        input logic [3:0] en, input int t,
                        output logic [3:0] d, output logic [3:0] f);
      int n;
      logic [15:0] w;
      logic [3:0]  nib;
      d = 4'h0;
      f = 4'h0;
      n = (cc[5:4] == 2'd0) ? 1 : (cc[5:4] == 2'd1) ? 2 : 4;
      if (nb) begin
         w   = exp_word(cc[7:6], t / 4, en);
         nib = 4'((w >> (12 - 4 * (t % 4))) & 16'hF);
         for (int k = 0; k < 4; k++)
            d[k] = (mc[1:0] == 2'd1) ? nib[3-k] : nib[k];
         f = ((t % 4) == 0) ? 4'hF : 4'h0;
      end else begin
         for (int k = 0; k < 4; k++) begin
            int s;
            s = int'(mc[2*k +: 2]);
            if (s < n) begin
               w    = exp_word(cc[7:6], (t / 16) * n + s, en);
               d[k] = w[15 - (t % 16)];
               f[k] = ((t % 16) == 0);
            end
         end
      end
   endtask

   task automatic run_vec(input int v);
      logic [28:0] e;
      int len, gap, badgap, bad, mv, t;
      logic [3:0] ed, ef, fa_d, fa_f, fe_d, fe_f;
      e = VEC[v];
      len = int'(e[28:21]);
      @(negedge clk);
      clk_cfg = e[20:13]; mux_cfg = e[12:5]; nibble_en = e[4]; ch_en = e[3:0];
      smp_i = base_i; smp_q = base_q; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      gap = 0; badgap = 0; bad = 0; mv = 0; t = 0;
      fa_d = 0; fa_f = 0; fe_d = 0; fe_f = 0;
      while (t < len) begin
         @(negedge clk);
         gap++;
         if (mv == 1) begin
            smp_valid = 1'b0; mv = 2;
         end else if (mv == 0 && t == 3) begin
            smp_valid = 1'b1; smp_i = ~base_i; smp_q = ~base_q; mv = 1;   // R10 ignored
         end
         if (sck_en) begin
            if (t > 0 && gap != int'(clk_cfg[3:0]) + 1) badgap++;
            gap = 0;
            model(e[20:13], e[12:5], e[4], e[3:0], t, ed, ef);
            if (pin_dat !== ed || pin_fs !== ef) begin
               if (bad == 0) begin fa_d = pin_dat; fa_f = pin_fs; fe_d = ed; fe_f = ef; end
               bad++;
            end
            t++;
         end
      end
      check(bad == 0, VTAG[v], $sformatf("vector %0d frame {dat,fs}", v),
            {24'h0, fa_d, fa_f}, {24'h0, fe_d, fe_f});
      check(badgap == 0, "R1", $sformatf("vector %0d strobe gap errors", v), badgap, 0);
      bad = 0;
      for (int i = 0; i < 2; i++) begin
         do @(negedge clk); while (!sck_en);
         if (pin_dat !== 4'h0 || pin_fs !== 4'h0) bad++;
      end
      check(bad == 0, "R10", $sformatf("vector %0d idle after frame", v), bad, 0);
      smp_i = base_i; smp_q = base_q;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: R10 run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int bad;
      base_i = {BI[3], BI[2], BI[1], BI[0]};
      base_q = {BQ[3], BQ[2], BQ[1], BQ[0]};
      smp_i = base_i;
      smp_q = base_q;
      repeat (4) @(negedge clk);
      check(pin_dat == 4'h0 && pin_fs == 4'h0 && sck_en == 1'b0, "R11",
            "outputs in reset", {27'h0, sck_en, pin_dat}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) run_vec(v);

      // mid-frame reset: outputs clear at once and no frame resumes
      @(negedge clk);
      clk_cfg = 8'h00; mux_cfg = 8'hE4; nibble_en = 1'b0; ch_en = 4'hF;
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(pin_dat == 4'h0 && pin_fs == 4'h0 && sck_en == 1'b0, "R11",
            "outputs during mid-frame reset", {27'h0, sck_en, pin_dat}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pin_dat !== 4'h0 || pin_fs !== 4'h0) bad++;
      end
      check(bad == 0, "R11", "no frame resumes after reset", bad, 0);

      // a frame after reset still works (stream count 1, order mode 1)
      run_vec(1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule